// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Edge-Triggered DMA Request

This block is the transmit half of a synchronous serial port. Software, or an external DMA engine, writes words into a one-word holding register through a small write-only register bus. When a frame begins and the shifter is idle, the word moves into a shift register and leaves MSB first on the serial data pin. Each bit lasts one period of an internally divided serial clock. A frame-sync pulse one serial clock wide marks the first bit of every frame.

The clock generator, the transmitter and the frame-sync generator each have their own enable bit. While the transmitter is disabled it is held in reset. After the transmitter is enabled it waits two serial clock periods before it becomes active. The DMA request is a single-cycle pulse produced only when the transmit-ready flag goes from low to high. A DMA engine that enables itself while ready is already high therefore receives no request. The safe restart sequence is: disable the transmitter, arm the DMA, then enable the transmitter again.

Top module: `sertx_top`

## Requirements
- R1: After reset, `sclk_o`, `sdata_o`, `fsync_o`, `tx_ready_o`, `dma_evt_o` and `underflow_o` are all low.
- R2: While the transmitter enable (control bit 1) is zero, `tx_ready_o` is low from the next cycle on. After the bit is set with the holding register empty, `tx_ready_o` is still low after the first falling edge of `sclk_o` and is high from the second falling edge.
- R3: `dma_evt_o` is a one-cycle pulse that occurs only in the cycle where `tx_ready_o` rises. While `tx_ready_o` stays high, no further pulse occurs.
- R4: A word written to the data register (address 2) while the transmitter is disabled is kept. After the transmitter is enabled, `tx_ready_o` stays low and no DMA pulse occurs until that word is sent.
- R5: A held word moves to the shifter only at a frame start while the shifter is idle. Because of that move, `tx_ready_o` rises, so each DMA pulse coincides with `fsync_o` high.
- R6: Each word is sent MSB first, one bit per `sclk_o` period, stable around the rising edge of `sclk_o`. The first bit coincides with `fsync_o` high.
- R7: With the clock generator enabled (control bit 0), `sclk_o` has a period of 2*(DIV+1) clock cycles, where DIV is bits [7:0] of the timing register (address 1). With the clock generator disabled, `sclk_o` is held low.
- R8: With the frame-sync generator enabled (control bit 2), frames start every FPER+1 `sclk_o` periods, where FPER is bits [15:8] of the timing register. `fsync_o` is high for exactly one `sclk_o` period per frame.
- R9: `underflow_o` is set when a frame starts while the transmitter is active, the shifter is idle and the holding register is empty. Disabling the transmitter clears it.
- R10: A word in the shifter always completes, including the last word when no further word follows. Only clearing the transmitter enable stops it; after that `sdata_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 timing, 2 data |
| bus_wdata | input | REG_W | Write data |
| sclk_o | output | 1 | Divided serial clock |
| sdata_o | output | 1 | Serial data, MSB first |
| fsync_o | output | 1 | Frame-sync pulse, one serial clock wide |
| tx_ready_o | output | 1 | Holding register can accept a word |
| dma_evt_o | output | 1 | One-cycle DMA request on rise of ready |
| underflow_o | output | 1 | A frame started with nothing to send |

## Verification
The bench builds the block with 16-bit words. This makes the data port 16 bits wide, so one timing write sets both the divider and the frame length. In the first phase the divider is 1 and the frame length equals the word length. Frames then run back to back, and the case where one word finishes in the same cycle as the next word is loaded is exercised continuously. In the second phase the divider is random and the frames are longer than a word, which leaves gaps. In that phase the bench disables the transmitter partway through a word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int SYNC_TICKS = 2;

  typedef struct packed {
    logic fs_en;
    logic tx_en;
    logic ck_en;
  } ctrl_t;

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8,
  parameter int FPER_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [DIV_W-1:0]  div,
  output logic [FPER_W-1:0] fper,
  output logic              data_wr,
  output logic [WORD_W-1:0] data_word
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [FPER_W-1:0] fper_q, fper_d;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    fper_d = fper_q;
    if (wr && addr == ADDR_CTRL) begin
      ctrl_d = ctrl_t'(wdata[2:0]);
    end
    if (wr && addr == ADDR_TIME) begin
      div_d  = wdata[DIV_W-1:0];
      fper_d = wdata[DIV_W +: FPER_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      fper_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      fper_q <= fper_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign div       = div_q;
  assign fper      = fper_q;
  assign data_wr   = wr && (addr == ADDR_DATA);
  assign data_word = wdata[WORD_W-1:0];

endmodule

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             bit_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  assign wrap = (cnt_q == div);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign bit_tick = en && wrap && sclk_q;

endmodule

// File: rtl/sertx_fsgen.sv
module sertx_fsgen #(
  parameter int FPER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FPER_W-1:0] fper,
  input  logic              bit_tick,
  output logic              fs_tick,
  output logic              fsync
);

  logic [FPER_W-1:0] fcnt_q, fcnt_d;
  logic              fs_q, fs_d;
  logic              at_start;

  assign at_start = (fcnt_q == '0);

  always_comb begin
    fcnt_d = fcnt_q;
    fs_d   = fs_q;
    if (!en) begin
      fcnt_d = '0;
      fs_d   = 1'b0;
    end else if (bit_tick) begin
      fcnt_d = (fcnt_q == fper) ? '0 : fcnt_q + 1'b1;
      fs_d   = at_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      fs_q   <= fs_d;
    end
  end

  assign fs_tick = en && bit_tick && at_start;
  assign fsync   = fs_q;

endmodule

// File: rtl/sertx_txpath.sv
module sertx_txpath
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              fs_tick,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] data_word,
  output logic              sdata,
  output logic              ready,
  output logic              dma_evt,
  output logic              underflow,
  output logic              busy
);

  localparam int CNT_W  = $clog2(WORD_W);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [SYNC_W-1:0] sync_q, sync_d;
  logic              active_q, active_d;
  logic              uflow_q, uflow_d;
  logic              rdy_dly_q;
  logic              last_bit, idle, load, miss;

  assign last_bit = busy_q && bit_tick && (bitcnt_q == '0);
  assign idle     = !busy_q || last_bit;
  assign load     = tx_en && active_q && fs_tick && idle && full_q;
  assign miss     = tx_en && active_q && fs_tick && idle && !full_q;

  // holding register
  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    if (load) full_d = 1'b0;
    if (data_wr) begin
      hold_d = data_word;
      full_d = 1'b1;
    end
  end

  // shifter
  always_comb begin
    shift_d  = shift_q;
    busy_d   = busy_q;
    bitcnt_d = bitcnt_q;
    if (!tx_en) begin
      shift_d  = '0;
      busy_d   = 1'b0;
      bitcnt_d = '0;
    end else if (load) begin
      shift_d  = hold_q;
      busy_d   = 1'b1;
      bitcnt_d = CNT_W'(WORD_W - 1);
    end else if (busy_q && bit_tick) begin
      shift_d = {shift_q[WORD_W-2:0], 1'b0};
      if (bitcnt_q == '0) busy_d = 1'b0;
      else                bitcnt_d = bitcnt_q - 1'b1;
    end
  end

  // enable synchronisation and underflow
  always_comb begin
    sync_d   = sync_q;
    active_d = active_q;
    uflow_d  = uflow_q;
    if (!tx_en) begin
      sync_d   = '0;
      active_d = 1'b0;
      uflow_d  = 1'b0;
    end else begin
      if (bit_tick && !active_q) begin
        sync_d   = sync_q + 1'b1;
        active_d = (sync_q == SYNC_W'(SYNC_TICKS - 1));
      end
      if (miss) uflow_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      full_q    <= 1'b0;
      shift_q   <= '0;
      busy_q    <= 1'b0;
      bitcnt_q  <= '0;
      sync_q    <= '0;
      active_q  <= 1'b0;
      uflow_q   <= 1'b0;
      rdy_dly_q <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      full_q    <= full_d;
      shift_q   <= shift_d;
      busy_q    <= busy_d;
      bitcnt_q  <= bitcnt_d;
      sync_q    <= sync_d;
      active_q  <= active_d;
      uflow_q   <= uflow_d;
      rdy_dly_q <= ready;
    end
  end

  assign ready     = active_q && !full_q;
  assign dma_evt   = ready && !rdy_dly_q;
  assign sdata     = busy_q && shift_q[WORD_W-1];
  assign underflow = uflow_q;
  assign busy      = busy_q;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8,
  parameter int FPER_W = 8,
  localparam int REG_W = (WORD_W > DIV_W + FPER_W) ? WORD_W : DIV_W + FPER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             fsync_o,
  output logic             tx_ready_o,
  output logic             dma_evt_o,
  output logic             underflow_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ctrl_t             ctl;
  logic              ck_en, tx_en, fs_en;
  logic [DIV_W-1:0]  div;
  logic [FPER_W-1:0] fper;
  logic              data_wr;
  logic [WORD_W-1:0] data_word;
  logic              bit_tick, fs_tick;
  logic              tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sertx_regs #(
    .WORD_W(WORD_W), .DIV_W(DIV_W), .FPER_W(FPER_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ctrl(ctl), .div(div), .fper(fper),
    .data_wr(data_wr), .data_word(data_word)
  );

  assign ck_en = ctl.ck_en;
  assign tx_en = ctl.tx_en;
  assign fs_en = ctl.fs_en;

  sertx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .en(ck_en), .div(div),
    .sclk(sclk_o), .bit_tick(bit_tick)
  );

  sertx_fsgen #(.FPER_W(FPER_W)) u_fsgen (
    .clk(clk), .rst_n(rst_int_n), .en(fs_en), .fper(fper),
    .bit_tick(bit_tick), .fs_tick(fs_tick), .fsync(fsync_o)
  );

  sertx_txpath #(.WORD_W(WORD_W)) u_txpath (
    .clk(clk), .rst_n(rst_int_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .fs_tick(fs_tick), .data_wr(data_wr), .data_word(data_word),
    .sdata(sdata_o), .ready(tx_ready_o), .dma_evt(dma_evt_o),
    .underflow(underflow_o), .busy(tx_busy)
  );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic ck_en,
  input logic tx_en,
  input logic busy,
  input logic sclk,
  input logic fsync,
  input logic ready,
  input logic evt,
  input logic uflow
);

  AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (ready && !$past(ready))); // R3

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R3

  AST_RDY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !ready); // R2

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_en |=> !sclk); // R7

  AST_LOAD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fsync); // R5

  AST_UFLOW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !uflow); // R9

endmodule

bind sertx_top sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ck_en(ck_en), .tx_en(tx_en), .busy(tx_busy),
  .sclk(sclk_o), .fsync(fsync_o), .ready(tx_ready_o), .evt(dma_evt_o),
  .uflow(underflow_o)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;

  localparam int W = 16;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [15:0]  wdata = '0;
  logic sclk, sdata, fsync, ready, evt, uflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sertx_top #(.WORD_W(W), .DIV_W(8), .FPER_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .sclk_o(sclk), .sdata_o(sdata), .fsync_o(fsync), .tx_ready_o(ready),
    .dma_evt_o(evt), .underflow_o(uflow)
  );

  always #5 clk = ~clk;

  // monitor
  event ev_rise, ev_fall;
  int   cyc = 0, last_rise_cyc = 0, last_period = 0;
  int   rise_cnt = 0, last_fs_idx = -1, fs_period = 0;
  int   evt_cnt = 0;
  bit   sclk_prev = 0, fs_at_prev_rise = 0, fs_width_bad = 0;
  bit   cap_en = 0;
  int   bitn = 0;
  logic [W-1:0] cur = '0;
  logic [W-1:0] cap_q[$];
  logic [W-1:0] exp_q[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (evt) evt_cnt++;
      if (sclk && !sclk_prev) begin
        rise_cnt++;
        last_period   = cyc - last_rise_cyc;
        last_rise_cyc = cyc;
        if (fsync && fs_at_prev_rise) fs_width_bad = 1;
        if (fsync && !fs_at_prev_rise) begin
          if (last_fs_idx >= 0) fs_period = rise_cnt - last_fs_idx;
          last_fs_idx = rise_cnt;
        end
        fs_at_prev_rise = fsync;
        if (cap_en) begin
          if (fsync) begin
            cur = {{(W-1){1'b0}}, sdata};
            bitn = 1;
          end else if (bitn != 0) begin
            cur = {cur[W-2:0], sdata};
            bitn++;
          end
          if (bitn == W) begin
            cap_q.push_back(cur);
            bitn = 0;
          end
        end
        -> ev_rise;
      end
      if (!sclk && sclk_prev) -> ev_fall;
    end
    sclk_prev = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // control bits: 0 clock gen, 1 transmitter, 2 frame sync
  function automatic logic [15:0] ctl(input bit ck, input bit tx, input bit fs);
    return {13'd0, fs, tx, ck};
  endfunction

  function automatic logic [15:0] timing(input int div, input int fper);
    return {fper[7:0], div[7:0]};
  endfunction

  function automatic int sclk_period(input int div);
    return 2 * (div + 1);
  endfunction

  task automatic wait_evt();
    do @(negedge clk); while (!evt);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int e0, ones, div2;
    logic [W-1:0] w;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sclk", sclk, 0);
    chk("R1 sdata", sdata, 0);
    chk("R1 fsync", fsync, 0);
    chk("R1 ready", ready, 0);
    chk("R1 evt", evt, 0);
    chk("R1 uflow", uflow, 0);

    // phase 1: div 1, back-to-back frames
    bus_write(2'd1, timing(1, W - 1));
    bus_write(2'd0, ctl(1, 0, 0));
    repeat (3) @(ev_rise);
    chk("R7 sclk period", last_period, sclk_period(1));

    // R2 sync delay and R3 single event
    @(ev_fall);
    e0 = evt_cnt;
    bus_write(2'd0, ctl(1, 1, 0));
    @(ev_fall);
    chk("R2 ready after 1st fall", ready, 0);
    @(ev_fall);
    chk("R2 ready after 2nd fall", ready, 1);
    chk("R3 evt at rise", evt, 1);
    repeat (3) @(negedge clk);
    chk("R3 one event", evt_cnt - e0, 1);
    repeat (100) @(negedge clk);
    chk("R3 no repeat event", evt_cnt - e0, 1);
    chk("R3 ready held", ready, 1);

    bus_write(2'd0, ctl(1, 0, 0));
    repeat (2) @(negedge clk);
    chk("R2 ready forced low", ready, 0);

    // R4 preload in reset
    w = W'($urandom);
    exp_q.push_back(w);
    bus_write(2'd2, w);
    e0 = evt_cnt;
    bus_write(2'd0, ctl(1, 1, 0));
    repeat (4) @(ev_fall);
    chk("R4 ready low with preload", ready, 0);
    chk("R4 no event with preload", evt_cnt - e0, 0);
    chk("R9 no underflow yet", uflow, 0);

    // R5/R6 streaming with DMA-like responder
    cap_en = 1;
    bus_write(2'd0, ctl(1, 1, 1));
    for (int i = 1; i < N; i++) begin
      wait_evt();
      chk("R5 event with frame sync", fsync, 1);
      w = (i == 1) ? 16'h8001 : (i == 2) ? 16'h7FFE : W'($urandom);
      exp_q.push_back(w);
      bus_write(2'd2, w);
    end
    wait_evt();
    chk("R5 last event with frame sync", fsync, 1);
    chk("R9 no underflow while fed", uflow, 0);
    repeat (W * 8 + 20) @(negedge clk);
    chk("R5 event count", evt_cnt - e0, N);
    chk("R9 underflow after starve", uflow, 1);
    chk("R8 frame period", fs_period, W);
    chk("R8 fsync width", fs_width_bad, 0);
    chk("R10 words captured", (cap_q.size() >= N) ? 1 : 0, 1);
    for (int i = 0; i < N; i++) begin
      if (i < cap_q.size())
        chk((i == N - 1) ? "R10 last word intact" : "R6 word MSB first", cap_q[i], exp_q[i]);
    end
    cap_en = 0;

    // phase 2: random divider, gaps, abort
    bus_write(2'd0, ctl(0, 0, 0));
    repeat (2) @(negedge clk);
    chk("R9 underflow cleared", uflow, 0);
    chk("R7 sclk parked", sclk, 0);
    div2 = 1 + ($urandom % 3);
    bus_write(2'd1, timing(div2, W + 2));
    w = W'($urandom) | 16'h8000;
    bus_write(2'd2, w);
    bus_write(2'd0, ctl(1, 0, 0));
    repeat (3) @(ev_rise);
    chk("R7 random period", last_period, sclk_period(div2));
    bus_write(2'd0, ctl(1, 1, 0));
    bus_write(2'd0, ctl(1, 1, 1));
    wait_evt();
    repeat (3) @(ev_rise);
    bus_write(2'd0, ctl(1, 0, 1));
    repeat (3) @(negedge clk);
    chk("R10 abort sdata", sdata, 0);
    chk("R10 abort ready", ready, 0);
    ones = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (sdata) ones++;
    end
    chk("R10 stays quiet after abort", ones, 0);
    chk("R8 frame period with gaps", fs_period, W + 3);

    done = 1;
    summary();
    $finish;
  end

endmodule